// File: doc/BRIEF.md
# Memory Interface Clock Divider

This block derives the serial clock for an external memory from the clock of the memory interface core. The caller gives two things: which of four core frequencies is running, and the memory clock frequency it wants. A small encoder divides the core frequency by the requested frequency, keeping the integer part. It turns that divisor into a 32-bit register image with three count fields (period, high edge, low edge) and a pass-through flag. The divider core then builds the output waveform from that image.

A divisor of 2 or more runs a counter over one output period. The output is high in the first half of the period and low in the rest. If the division comes out below 2, the block enters pass-through: the core clock itself drives the memory clock. A changed request never cuts a period short. The new image is taken only when the current period ends, so no runt pulse reaches the memory. The image in use is visible on an output port, which shows what the hardware is actually running.

Top module: `memclk_div`

## Requirements
- R1: While `rst_n` is low at a clock edge, `mem_clk` is 0 and `cfg_word` is 0 after that edge.
- R2: The divisor is `core_mhz / target_mhz` (integer division), where `core_sel` 0, 1, 2, 3 means 80, 120, 160, 240 MHz. A `target_mhz` of 0 gives a divisor of 0.
- R3: For a divisor d of 2 or more, `cfg_word` holds d-1 in bits [23:16], d/2-1 in bits [15:8], d-1 in bits [7:0], and 0 in bit 31 and bits [30:24].
- R4: For a divisor below 2, `cfg_word` is 32'h8000_0000 (pass-through flag in bit 31) and `mem_clk` equals `clk_core` in both clock phases.
- R5: For a divisor d of 2 or more, `mem_clk` repeats every d core cycles.
- R6: For a divisor d of 2 or more, `mem_clk` is high for d/2 core cycles and low for d-d/2 core cycles. With an odd d the high phase is the shorter one.
- R7: A change of `core_sel` or `target_mhz` takes effect only after the running period has completed with its old high and low times. The first cycle of every period is high.
- R8: Low-speed start-up setting: `core_sel`=0 with `target_mhz`=20 gives divisor 4, `cfg_word` 32'h0003_0103, and a 20 MHz memory clock (period of 4 core cycles, 2 high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_core | input | 1 | Memory interface core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_sel | input | 2 | Core frequency code: 0=80, 1=120, 2=160, 3=240 MHz |
| target_mhz | input | 8 | Requested memory clock frequency in MHz |
| cfg_word | output | 32 | Register image in use: pass-through flag, period, high and low counts |
| mem_clk | output | 1 | Memory serial clock |

## Verification
The bench tries all four core codes against requests that give divisors 1 through 8. For each one it checks the field image and measures the waveform, so a wrong frequency table, a misplaced field or an off-by-one in the high count appears as a different number.

Two requests fall outside the divisible range: zero, and a frequency above the core frequency. These show whether pass-through is chosen and whether the output then follows both edges of the core clock. A request changed two cycles into a long period tells a boundary-aligned update apart from an immediate one: the interrupted period must still show its full old high and low times.

// File: rtl/memclk_pkg.sv
// Package: shared field widths and the register image layout for the
// memory clock divider. Assumes every count fits in FIELD_W bits.
package memclk_pkg;

    localparam int FIELD_W = 8;
    localparam int WORD_W  = 32;

    // Register image: bit 31 pass-through, [23:16] period, [15:8] high, [7:0] low
    typedef struct packed {
        logic               bypass;
        logic [6:0]         rsvd;
        logic [FIELD_W-1:0] n_cnt;
        logic [FIELD_W-1:0] h_cnt;
        logic [FIELD_W-1:0] l_cnt;
    } clkcfg_t;

endpackage

// File: rtl/memclk_req_encode.sv
// Module: turns a core frequency code and a requested memory frequency
// into a register image. Assumes FREQ_W <= FIELD_W so the counts fit.
// Purely combinational.
module memclk_req_encode
    import memclk_pkg::*;
#(
    parameter int FREQ_W  = 8,
    parameter int F0_MHZ  = 80,
    parameter int F1_MHZ  = 120,
    parameter int F2_MHZ  = 160,
    parameter int F3_MHZ  = 240
) (
    input  logic [1:0]        core_sel,
    input  logic [FREQ_W-1:0] target_mhz,
    output clkcfg_t           req_cfg
);

    logic [FREQ_W-1:0] core_mhz;
    logic [FREQ_W-1:0] divisor;

    // Look up the core frequency for the select code
    always_comb begin
        case (core_sel)
            2'd0:    core_mhz = FREQ_W'(F0_MHZ);
            2'd1:    core_mhz = FREQ_W'(F1_MHZ);
            2'd2:    core_mhz = FREQ_W'(F2_MHZ);
            default: core_mhz = FREQ_W'(F3_MHZ);
        endcase
    end

    // Integer divisor; a zero request yields zero
    always_comb begin
        if (target_mhz == '0) divisor = '0;
        else                  divisor = core_mhz / target_mhz;
    end

    // Build the image: pass-through below 2, count fields otherwise
    always_comb begin
        req_cfg = '0;
        if (divisor < FREQ_W'(2)) begin
            req_cfg.bypass = 1'b1;
        end else begin
            req_cfg.n_cnt = FIELD_W'(divisor - 1'b1);
            req_cfg.h_cnt = FIELD_W'((divisor >> 1) - 1'b1);
            req_cfg.l_cnt = FIELD_W'(divisor - 1'b1);
        end
    end

endmodule

// File: rtl/memclk_phase_gen.sv
// Module: period counter and registered divided clock. Holds the image
// in use and takes a new image only at the end of a period (or on every
// cycle in pass-through, where the counter rests at 0). Output is high
// while the count is at or below the high count.
module memclk_phase_gen
    import memclk_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  clkcfg_t req_cfg,
    output clkcfg_t act_cfg,
    output logic    div_q
);

    logic [FIELD_W-1:0] cnt;
    logic [FIELD_W-1:0] cnt_inc;
    logic               wrap;

    // Period end: last count reached, or pass-through
    always_comb begin
        wrap    = act_cfg.bypass || (cnt == act_cfg.n_cnt);
        cnt_inc = cnt + 1'b1;
    end

    // Advance the counter, load a new image at wrap, register the output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            act_cfg <= '0;
            div_q   <= 1'b0;
        end else if (wrap) begin
            cnt     <= '0;
            act_cfg <= req_cfg;
            div_q   <= 1'b1;
        end else begin
            cnt     <= cnt_inc;
            div_q   <= (cnt_inc <= act_cfg.h_cnt);
        end
    end

    p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act_cfg.n_cnt);

    p_hold_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(act_cfg));

    p_start_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> div_q);

    p_fall_point_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(div_q) && !act_cfg.bypass) |-> (cnt == act_cfg.h_cnt + 1'b1));

    p_bypass_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_cfg.bypass |-> (cnt == '0));

endmodule

// File: rtl/memclk_div.sv
// Module: top of the memory clock divider. Encodes the request, runs the
// period generator, and selects the core clock itself in pass-through.
// Assumes the select changes only at period boundaries (guaranteed by
// the generator) and that clk_core is free-running.
module memclk_div
    import memclk_pkg::*;
#(
    parameter int FREQ_W = 8,
    parameter int F0_MHZ = 80,
    parameter int F1_MHZ = 120,
    parameter int F2_MHZ = 160,
    parameter int F3_MHZ = 240
) (
    input  logic              clk_core,
    input  logic              rst_n,
    input  logic [1:0]        core_sel,
    input  logic [FREQ_W-1:0] target_mhz,
    output logic [WORD_W-1:0] cfg_word,
    output logic              mem_clk
);

    clkcfg_t req_cfg;
    clkcfg_t act_cfg;
    logic    div_q;

    memclk_req_encode #(
        .FREQ_W (FREQ_W),
        .F0_MHZ (F0_MHZ),
        .F1_MHZ (F1_MHZ),
        .F2_MHZ (F2_MHZ),
        .F3_MHZ (F3_MHZ)
    ) u_enc (
        .core_sel   (core_sel),
        .target_mhz (target_mhz),
        .req_cfg    (req_cfg)
    );

    memclk_phase_gen u_gen (
        .clk     (clk_core),
        .rst_n   (rst_n),
        .req_cfg (req_cfg),
        .act_cfg (act_cfg),
        .div_q   (div_q)
    );

    // Drive the register image and pick the clock source
    always_comb begin
        cfg_word = act_cfg;
        mem_clk  = act_cfg.bypass ? clk_core : div_q;
    end

    p_bypass_word_r4: assert property (@(posedge clk_core) disable iff (!rst_n)
        cfg_word[31] |-> (cfg_word[30:0] == '0));

    p_fields_r3: assert property (@(posedge clk_core) disable iff (!rst_n)
        !cfg_word[31] |-> (cfg_word[30:24] == '0));

endmodule

// File: tb/tb_memclk_div.sv
module tb_memclk_div;

    logic        clk_core = 1'b0;
    logic        rst_n    = 1'b0;
    logic [1:0]  core_sel = 2'd0;
    logic [7:0]  target_mhz = 8'd0;
    logic [31:0] cfg_word;
    logic        mem_clk;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    memclk_div dut (
        .clk_core   (clk_core),
        .rst_n      (rst_n),
        .core_sel   (core_sel),
        .target_mhz (target_mhz),
        .cfg_word   (cfg_word),
        .mem_clk    (mem_clk)
    );

    always #10 clk_core = ~clk_core;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk_core) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    function automatic int mhz_of(input int sel);
        case (sel)
            0: return 80;
            1: return 120;
            2: return 160;
            default: return 240;
        endcase
    endfunction

    task automatic settle();
        repeat (24) @(negedge clk_core);
    endtask

    // From a negedge sample, find a rising edge, then count high and low samples
    task automatic measure(output int hi, output int per);
        int lo;
        bit prev;
        prev = mem_clk;
        @(negedge clk_core);
        while (!(mem_clk && !prev)) begin
            prev = mem_clk;
            @(negedge clk_core);
        end
        hi = 0;
        while (mem_clk) begin hi++; @(negedge clk_core); end
        lo = 0;
        while (!mem_clk) begin lo++; @(negedge clk_core); end
        per = hi + lo;
    endtask

    task automatic check_bypass(input string req);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk_core); #5;
            check(mem_clk == 1'b1, req, mem_clk, 1);
            @(negedge clk_core); #5;
            check(mem_clk == 1'b0, req, mem_clk, 0);
        end
    endtask

    task automatic apply_and_check(input int sel, input int tgt);
        int d, hi, per;
        logic [31:0] exp_w;
        core_sel   = 2'(sel);
        target_mhz = 8'(tgt);
        settle();
        d = (tgt == 0) ? 0 : mhz_of(sel) / tgt;
        if (d < 2) begin
            exp_w = 32'h8000_0000;
            check(cfg_word == exp_w, "R4 word", cfg_word, exp_w);
            check_bypass("R4 follow");
            @(negedge clk_core);
        end else begin
            exp_w = {8'h00, 8'(d - 1), 8'(d / 2 - 1), 8'(d - 1)};
            check(cfg_word == exp_w, "R2/R3 word", cfg_word, exp_w);
            measure(hi, per);
            check(per == d, "R5 period", per, d);
            check(hi == d / 2, "R6 high", hi, d / 2);
        end
    endtask

    initial begin
        int hi, per, nh, nl;
        // R1: reset state
        repeat (3) @(negedge clk_core);
        check(mem_clk == 1'b0, "R1 clk", mem_clk, 0);
        check(cfg_word == 32'h0, "R1 word", cfg_word, 0);
        @(negedge clk_core);
        rst_n = 1'b1;

        // R8: low-speed start-up setting
        core_sel = 2'd0; target_mhz = 8'd20;
        settle();
        check(cfg_word == 32'h0003_0103, "R8 word", cfg_word, 32'h0003_0103);
        measure(hi, per);
        check(per == 4, "R8 period", per, 4);
        check(hi == 2, "R8 high", hi, 2);

        // R2..R6: sweep all core codes and divisors 1..8
        for (int s = 0; s < 4; s++) begin
            for (int d = 1; d <= 8; d++) begin
                apply_and_check(s, mhz_of(s) / d);
            end
            apply_and_check(s, 0);
            apply_and_check(s, 255);
        end

        // R7: change two cycles into a divisor-8 period
        core_sel = 2'd0; target_mhz = 8'd10;
        settle();
        measure(hi, per);            // returns at first high sample of a period
        @(negedge clk_core);
        @(negedge clk_core);
        target_mhz = 8'd40;          // divisor 2 requested mid-period
        nh = 0;
        while (mem_clk) begin nh++; @(negedge clk_core); end
        nl = 0;
        while (!mem_clk) begin nl++; @(negedge clk_core); end
        check(nh == 2, "R7 old high kept", nh, 2);
        check(nl == 4, "R7 old low kept", nl, 4);
        measure(hi, per);
        check(per == 2, "R7 new period", per, 2);
        check(hi == 1, "R7 new high", hi, 1);
        check(cfg_word == 32'h0001_0001, "R7 new word", cfg_word, 32'h0001_0001);

        // R1: reset again from a running divided clock
        rst_n = 1'b0;
        @(negedge clk_core);
        @(negedge clk_core);
        check(mem_clk == 1'b0, "R1 re-reset clk", mem_clk, 0);
        check(cfg_word == 32'h0, "R1 re-reset word", cfg_word, 0);

        finish_run();
    end

endmodule